// File: doc/BRIEF.md
# Legacy System Board Configuration Registers

This block is the byte-wide configuration register file of a PC-compatible system board. A host bus presents a 16-bit I/O port address together with a read strobe or a write strobe. The block answers a fixed, irregular set of eight port addresses and keeps seven byte registers behind them. One address is a constant-zero port with no storage.

The stored bytes drive board-level controls: an alternate A20 gate, a primary serial port enable, and a parallel port enable with a 2-bit base select. The block also produces the decoded parallel base address, so the parallel controller elsewhere on the board can be placed without further decode. Reads are combinational from the registers. A read of any port outside the set returns all ones, as an undriven ISA-style bus would.

Top module: `legacy_board_cfg`

## Requirements
- R1: The block decodes ports 0x91, 0x92, 0x94, 0x102, 0x103, 0x104, 0x105 and 0x190. A write with `wr_en` high to any of these ports except 0x91 is stored on that rising clock edge. A read with `rd_en` high returns the stored byte in the same cycle.
- R2: `rdata` is 0xFF for a read of any port outside the decoded set, and whenever `rd_en` is low.
- R3: Port 0x91 always reads 0x00. A write to 0x91 changes no register and no output.
- R4: `a20_alt` equals bit 1 of the byte last written to port 0x92. A read of 0x92 returns that whole byte unchanged.
- R5: `ser_en` equals bit 2 of the register at port 0x102.
- R6: `par_sel` equals bits 6:5 of the register at port 0x102. `par_en` is high only when bit 4 of that register is 1 and bits 6:5 are not 3.
- R7: `par_base` is 0x3BC for select 0, 0x378 for select 1 and 0x278 for select 2. It is 0x0000 whenever `par_en` is low.
- R8: A read of port 0x102 returns the stored byte with bit 3 forced to 1. The stored bit itself is not altered.
- R9: After reset, the register at 0x102 holds 0x10 and every other register holds 0x00. This gives `par_en` = 1, `par_base` = 0x3BC, `ser_en` = 0 and `a20_alt` = 0.
- R10: A write to a port outside the decoded set changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 16 | I/O port address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| a20_alt | output | 1 | Alternate A20 gate |
| ser_en | output | 1 | Primary serial port enable |
| par_en | output | 1 | Parallel port enable |
| par_sel | output | 2 | Parallel base select field |
| par_base | output | 16 | Decoded parallel base address, 0 when disabled |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `addr` and `wdata` are steady across the clock edge on which a write is captured. The stimulus meets both assumptions by driving every input on the falling clock edge and raising only one strobe per operation. Random addresses are drawn mostly from the decoded set and partly from the whole 16-bit space, so unmapped writes and reads occur mixed in with normal traffic. Directed cases cover each parallel select value, the constant-zero port and a read with the strobe low.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NPORT  = 8;
  localparam int NREG   = NPORT - 1;

  // port index 0 is the constant-zero port; port i+1 holds register i
  localparam logic [ADDR_W-1:0] PORT_ADDR [NPORT] = '{
    16'h0091, 16'h0092, 16'h0094, 16'h0102,
    16'h0103, 16'h0104, 16'h0105, 16'h0190
  };

  localparam int REG_SYSCTL = 0;
  localparam int REG_PERIPH = 2;

  localparam logic [DATA_W-1:0] REG_RST [NREG] = '{
    8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00
  };

  localparam logic [DATA_W-1:0] REG_FORCE [NREG] = '{
    8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00
  };

  localparam int BIT_A20   = 1;
  localparam int BIT_SER   = 2;
  localparam int BIT_PAR   = 4;
  localparam int SEL_LO    = 5;

  typedef enum logic [1:0] {
    PBASE_3BC  = 2'd0,
    PBASE_378  = 2'd1,
    PBASE_278  = 2'd2,
    PBASE_NONE = 2'd3
  } par_sel_e;

  function automatic logic [ADDR_W-1:0] base_of(par_sel_e sel);
    case (sel)
      PBASE_3BC: return 16'h03BC;
      PBASE_378: return 16'h0378;
      PBASE_278: return 16'h0278;
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/lbc_addr_decode.sv
module lbc_addr_decode
  import lbc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NP = NPORT
) (
  input  logic [AW-1:0] addr,
  output logic [NP-1:0] hit
);

  for (genvar gi = 0; gi < NP; gi++) begin : g_cmp
    assign hit[gi] = (addr == PORT_ADDR[gi]);
  end

endmodule

// File: rtl/lbc_reg_bank.sv
module lbc_reg_bank
  import lbc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NP = NPORT,
  localparam int NR = NP - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [NP-1:0] hit,
  output logic [DW-1:0] reg_q [NR]
);

  logic [DW-1:0] reg_d  [NR];
  logic [NR-1:0] reg_we;

  for (genvar gi = 0; gi < NR; gi++) begin : g_reg
    assign reg_we[gi] = wr_en & hit[gi+1];

    always_comb begin
      reg_d[gi] = reg_q[gi];
      if (reg_we[gi]) begin
        reg_d[gi] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[gi] <= REG_RST[gi];
      end else begin
        reg_q[gi] <= reg_d[gi];
      end
    end

    AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit[gi+1]) |=> reg_q[gi] == $past(wdata)); // R1
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && hit[gi+1]) |=> $stable(reg_q[gi])); // R10
  end

endmodule

// File: rtl/lbc_read_mux.sv
module lbc_read_mux
  import lbc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NP = NPORT,
  localparam int NR = NP - 1
) (
  input  logic          rd_en,
  input  logic [NP-1:0] hit,
  input  logic [DW-1:0] reg_q [NR],
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] sel_val;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NR; i++) begin
      sel_val = sel_val | ((reg_q[i] | REG_FORCE[i]) & {DW{hit[i+1]}});
    end
  end

  always_comb begin
    if (!rd_en || !(|hit)) begin
      rdata = '1;
    end else if (hit[0]) begin
      rdata = '0;
    end else begin
      rdata = sel_val;
    end
  end

endmodule

// File: rtl/lbc_port_map.sv
module lbc_port_map
  import lbc_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          a20_bit,
  input  logic          ser_bit,
  input  logic          par_bit,
  input  logic [1:0]    sel_bits,
  output logic          a20_alt,
  output logic          ser_en,
  output logic          par_en,
  output logic [1:0]    par_sel,
  output logic [AW-1:0] par_base
);

  par_sel_e sel;

  always_comb begin
    sel      = par_sel_e'(sel_bits);
    a20_alt  = a20_bit;
    ser_en   = ser_bit;
    par_sel  = sel_bits;
    par_en   = par_bit && (sel != PBASE_NONE);
    par_base = par_en ? base_of(sel) : '0;
  end

endmodule

// File: rtl/legacy_board_cfg.sv
module legacy_board_cfg
  import lbc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NP = NPORT,
  localparam int NR = NP - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          a20_alt,
  output logic          ser_en,
  output logic          par_en,
  output logic [1:0]    par_sel,
  output logic [AW-1:0] par_base
);

  logic [NP-1:0] hit;
  logic [DW-1:0] reg_q [NR];

  lbc_addr_decode #(.AW(AW), .NP(NP)) u_dec (
    .addr (addr),
    .hit  (hit)
  );

  lbc_reg_bank #(.DW(DW), .NP(NP)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (wdata),
    .hit   (hit),
    .reg_q (reg_q)
  );

  lbc_read_mux #(.DW(DW), .NP(NP)) u_rmux (
    .rd_en (rd_en),
    .hit   (hit),
    .reg_q (reg_q),
    .rdata (rdata)
  );

  lbc_port_map #(.AW(AW)) u_map (
    .a20_bit  (reg_q[REG_SYSCTL][BIT_A20]),
    .ser_bit  (reg_q[REG_PERIPH][BIT_SER]),
    .par_bit  (reg_q[REG_PERIPH][BIT_PAR]),
    .sel_bits (reg_q[REG_PERIPH][SEL_LO+1:SEL_LO]),
    .a20_alt  (a20_alt),
    .ser_en   (ser_en),
    .par_en   (par_en),
    .par_sel  (par_sel),
    .par_base (par_base)
  );

  AST_DECODE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R1
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (hit == '0)) |-> rdata == '1); // R2
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '1); // R2
  AST_ZERO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 16'h0091) |-> rdata == '0); // R3
  AST_A20_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'h0092) |=> a20_alt == $past(wdata[BIT_A20])); // R4
  AST_SER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'h0102) |=> ser_en == $past(wdata[BIT_SER])); // R5
  AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (par_sel == 2'd3) |-> !par_en); // R6
  AST_PAR_OFF_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en |-> par_base == '0); // R7
  AST_PERIPH_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 16'h0102) |-> rdata[3]); // R8

endmodule

// File: tb/legacy_board_cfg_bench.sv
`timescale 1ns/1ps
module legacy_board_cfg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        a20_alt, ser_en, par_en;
  logic [1:0]  par_sel;
  logic [15:0] par_base;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [7];

  localparam logic [15:0] PORTS [8] = '{16'h0091, 16'h0092, 16'h0094, 16'h0102,
                                        16'h0103, 16'h0104, 16'h0105, 16'h0190};

  always #2.5 clk = ~clk;

  legacy_board_cfg u_legacy_board_cfg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .a20_alt(a20_alt), .ser_en(ser_en),
    .par_en(par_en), .par_sel(par_sel), .par_base(par_base)
  );

  function automatic int port_idx(logic [15:0] a);
    for (int i = 0; i < 8; i++) if (PORTS[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    int k = port_idx(a);
    if (k < 0) return 8'hFF;
    if (k == 0) return 8'h00;
    if (k == 3) return m[k-1] | 8'h08;
    return m[k-1];
  endfunction

  function automatic logic exp_pen();
    return m[2][4] && (m[2][6:5] != 2'd3);
  endfunction

  function automatic logic [15:0] exp_base();
    if (!exp_pen()) return 16'h0000;
    case (m[2][6:5])
      2'd0: return 16'h03BC;
      2'd1: return 16'h0378;
      default: return 16'h0278;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outputs(string tag);
    chk({tag, " R4 a20"}, {15'd0, a20_alt}, {15'd0, m[0][1]});
    chk({tag, " R5 ser"}, {15'd0, ser_en}, {15'd0, m[2][2]});
    chk({tag, " R6 pen"}, {15'd0, par_en}, {15'd0, exp_pen()});
    chk({tag, " R6 sel"}, {14'd0, par_sel}, {14'd0, m[2][6:5]});
    chk({tag, " R7 base"}, par_base, exp_base());
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    int k = port_idx(a);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (k >= 1) m[k-1] = d;
  endtask

  task automatic do_read(logic [15:0] a, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    chk({tag, " read"}, {8'd0, rdata}, {8'd0, exp_read(a)});
    rd_en = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 8; i++) do_read(PORTS[i], tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A21));
    for (int i = 0; i < 7; i++) m[i] = 8'h00;
    m[2] = 8'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk_outputs("R9 reset");
    chk("R9 reset base", par_base, 16'h03BC);
    read_all("R9 R8 R1 reset");

    // R2 strobe low and unmapped reads
    @(negedge clk);
    addr = 16'h0092; rd_en = 1'b0; #1;
    chk("R2 idle read", {8'd0, rdata}, 16'h00FF);
    do_read(16'h03BC, "R2 unmapped");
    do_read(16'h0093, "R2 unmapped");

    // R4 full byte and A20 bit
    do_write(16'h0092, 8'hFF); chk_outputs("R4 set"); do_read(16'h0092, "R4");
    do_write(16'h0092, 8'hFD); chk_outputs("R4 clear"); do_read(16'h0092, "R4");

    // R5 R6 R7 every select, with and without enable bits
    for (int s = 0; s < 4; s++) begin
      do_write(16'h0102, 8'(s << 5) | 8'h14);
      chk_outputs("R6 R7 enabled sel");
      do_read(16'h0102, "R8 sel");
      do_write(16'h0102, 8'(s << 5));
      chk_outputs("R6 R7 disabled sel");
      chk("R7 off base", par_base, 16'h0000);
    end
    // R8 stored bit 3 clear but reads set, stored bit set reads set
    do_write(16'h0102, 8'h08); do_read(16'h0102, "R8 stored");

    // R3 writes to zero port ignored
    do_write(16'h0091, 8'hAB); chk_outputs("R3 no effect"); read_all("R3 after write");

    // R10 unmapped writes ignored
    do_write(16'h0093, 8'h5A); do_write(16'h0190 ^ 16'h8000, 8'hC3);
    chk_outputs("R10 no effect"); read_all("R10 after write");

    // R1 random traffic
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = ($urandom_range(0, 9) < 7) ? PORTS[$urandom_range(0, 7)] : 16'($urandom());
      d = 8'($urandom());
      if ($urandom_range(0, 1) == 1) begin
        do_write(a, d);
        chk_outputs("R1 R10 random write");
      end else begin
        do_read(a, "R1 R2 random");
      end
    end

    // R9 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 7; i++) m[i] = 8'h00;
    m[2] = 8'h10;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outputs("R9 re-reset");
    read_all("R9 re-reset");

    finish_run();
  end

endmodule